// File: doc/BRIEF.md
# Four-Pin Port Controller with Clock Drive and Wake-on-Change

This block controls four bidirectional pads of a small controller. Each pin has its own direction bit and can drive a value from a data latch. Pins 1 and 2 are open-drain: they can only pull low or release. Pins 0 and 3 are push-pull and can have a weak pull-up. Two select bits can replace the latch data with the timer's counting clock. Select bit 0 drives the clock on pin 0 and its inverse on pin 3. Select bit 1 drives the clock on pin 1 and its inverse on pin 2.

The core enters sleep with a one-cycle request. At that moment the block stores the synchronised pad levels. While asleep, any difference from that stored value raises a one-cycle wake request, ends sleep and sets a sticky wake flag. Only a watchdog reset clears the flag. Software reaches everything through a small register bus:

| Address | Register | Access |
|---|---|---|
| 0 | Port data | Read gives the synchronised pad levels; write loads the latch |
| 1 | Direction | Write-only; reads as zero |
| 2 | Select | Read/write |
| 3 | Control | Read/write, with the wake flag in bit 3 |

Top module: `pinport_top`

## Requirements
- R1: Direction register (address 1) is write-only and reads as 0. Bit value 1 makes the pin an input and 0 makes it an output. After reset all four pins are inputs, so `padOe` is 0000.
- R2: With select bit 0 (address 2, bit 0) at 1, pin 0 carries `timerClk` and pin 3 carries its inverse. At 0, pins 0 and 3 carry latch bits 0 and 3.
- R3: With select bit 1 (address 2, bit 1) at 1, pin 1 carries `timerClk` and pin 2 carries its inverse. At 0, pins 1 and 2 carry latch bits 1 and 2.
- R4: Pins 1 and 2 are open-drain. `padOut` on them is always 0, and `padOe` is 1 only when the pin is an output and its selected value is 0. Pins 0 and 3 drive `padOut` with the selected value, and `padOe` with the inverse of their direction bit.
- R5: The pull-up enable is active-low. Control bit 0 (address 3) at 0 sets `padPu` on pins 0 and 3 whenever those pins are inputs. At 1 it clears them. `padPu` on pins 1 and 2 is always 0. Reset value of the bit is 0.
- R6: The wake-on-change enable is active-low. Control bit 1 (address 3) at 1 blocks any wake while asleep, so the core stays asleep. Reset value of the bit is 0.
- R7: A one-cycle `sleepReq` sets `inSleep` and stores the synchronised pad levels. While asleep with wake enabled, a pad change gives a one-cycle `wakeReq` in the third cycle after the change. That same edge clears `inSleep` and sets the wake flag, read at address 3 bit 3. A pad change while awake gives no wake.
- R8: `wdtReset` clears the wake flag and ends sleep at the next edge.
- R9: Select bit 2 (address 2) appears on `counterSrcRc`. A 1 chooses the oscillator-input role for the counter pin, and a 0 chooses the clock-input role. Select bits 3..0 read back as written.
- R10: Address 0 reads the pad levels after a two-stage synchroniser, so a change is visible after the second rising edge. Writing address 0 updates the data latch. After reset the latch, select and control registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 4 | Register write data |
| regRdata | output | 4 | Register read data (combinational) |
| padIn | input | 4 | Pad input levels, asynchronous |
| padOut | output | 4 | Pad output values |
| padOe | output | 4 | Pad output enables |
| padPu | output | 4 | Pad weak pull-up enables |
| timerClk | input | 1 | Timer counting clock to route onto pins |
| sleepReq | input | 1 | One-cycle request to enter sleep |
| wdtReset | input | 1 | Watchdog reset pulse |
| wakeReq | output | 1 | One-cycle wake request |
| inSleep | output | 1 | Sleep state |
| counterSrcRc | output | 1 | Counter pin role select |

## Verification
The assertions assume three things about the inputs:
- `rstN` is low from time zero.
- `sleepReq` and `wdtReset` are synchronous, and a stray `sleepReq` during sleep does no harm.
- `padIn` may change at any time, because it passes through the synchroniser before any comparison.

The stimulus drives every input on the falling edge and holds the pads steady for several cycles before each sleep entry, so the stored snapshot matches the settled levels. Each pin is then toggled alone, in both directions, so the wake latency can be counted edge by edge. The output checks sweep all latch, direction and select values against both timer clock levels.

// File: rtl/pinport_pkg.sv
`timescale 1ns/1ps
package pinport_pkg;
  localparam int PIN_N = 4;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 3;
  localparam int PAIR_N = PIN_N / 2;
  localparam logic [PIN_N-1:0] OPEN_DRAIN_MASK = 4'b0110;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_DATA = 2'd0,
    ADDR_DIR  = 2'd1,
    ADDR_SEL  = 2'd2,
    ADDR_CTRL = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic             latchWe;
    logic             snapTake;
    logic [PIN_N-1:0] wdata;
  } dpStrobe_t;
endpackage

// File: rtl/pinport_datapath.sv
`timescale 1ns/1ps
module pinport_datapath
  import pinport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [PIN_N-1:0] dirIn,
  input  logic [PAIR_N-1:0] clkSel,
  input  logic             puDisable,
  input  logic             timerClk,
  input  logic [PIN_N-1:0] padIn,
  output logic [PIN_N-1:0] padOut,
  output logic [PIN_N-1:0] padOe,
  output logic [PIN_N-1:0] padPu,
  output logic [PIN_N-1:0] syncIn,
  output logic             changeDet
);

  logic [PIN_N-1:0] syncChain [SYNC_STAGES];
  logic [PIN_N-1:0] latchQ;
  logic [PIN_N-1:0] snapQ;
  logic [PIN_N-1:0] pinVal;

  // input synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain[0] <= '0;
    else       syncChain[0] <= padIn;
  end

  for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncChain[k] <= '0;
      else       syncChain[k] <= syncChain[k-1];
    end
  end

  assign syncIn = syncChain[SYNC_STAGES-1];

  // data latch and sleep snapshot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      snapQ  <= '0;
    end else begin
      if (strobe.latchWe)  latchQ <= strobe.wdata;
      if (strobe.snapTake) snapQ  <= syncIn;
    end
  end

  assign changeDet = |(syncIn ^ snapQ);

  // pair p: true clock on pin p, inverted clock on the mirror pin
  for (genvar p = 0; p < PAIR_N; p++) begin : g_pair
    localparam int MIRROR = PIN_N - 1 - p;
    always_comb begin
      pinVal[p]      = clkSel[p] ? timerClk  : latchQ[p];
      pinVal[MIRROR] = clkSel[p] ? ~timerClk : latchQ[MIRROR];
    end
  end

  // pad drivers
  for (genvar i = 0; i < PIN_N; i++) begin : g_pin
    if (OPEN_DRAIN_MASK[i]) begin : g_od
      assign padOut[i] = 1'b0;
      assign padOe[i]  = ~dirIn[i] & ~pinVal[i];
      assign padPu[i]  = 1'b0;
    end else begin : g_pp
      assign padOut[i] = pinVal[i];
      assign padOe[i]  = ~dirIn[i];
      assign padPu[i]  = ~puDisable & dirIn[i];
    end

    // input pins never drive the pad
    assert_input_released_R1: assert property (
      @(posedge clk) disable iff (!rstN) dirIn[i] |-> !padOe[i]);
  end

endmodule

// File: rtl/pinport_ctrl.sv
`timescale 1ns/1ps
module pinport_ctrl
  import pinport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [PIN_N-1:0]  regWdata,
  output logic [PIN_N-1:0]  regRdata,
  input  logic              sleepReq,
  input  logic              wdtReset,
  input  logic [PIN_N-1:0]  syncIn,
  input  logic              changeDet,
  output dpStrobe_t         strobe,
  output logic [PIN_N-1:0]  dirQ,
  output logic [PAIR_N-1:0] clkSel,
  output logic              puDisable,
  output logic              counterSrcRc,
  output logic              wakeReq,
  output logic              inSleep
);

  logic [PIN_N-1:0]  selQ;
  logic [CTRL_W-1:0] ctrlQ;
  logic              asleepQ;
  logic              flagQ;
  logic              wakeReqQ;
  logic              wakeEvt;
  logic              enterSleep;
  regAddr_e          addrE;

  assign addrE      = regAddr_e'(regAddr);
  assign wakeEvt    = asleepQ & ~ctrlQ[1] & changeDet & ~wdtReset;
  assign enterSleep = sleepReq & ~asleepQ & ~wdtReset;

  always_comb begin
    strobe          = '0;
    strobe.latchWe  = regWe && (addrE == ADDR_DATA);
    strobe.snapTake = enterSleep;
    strobe.wdata    = regWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ     <= '1;
      selQ     <= '0;
      ctrlQ    <= '0;
      asleepQ  <= 1'b0;
      flagQ    <= 1'b0;
      wakeReqQ <= 1'b0;
    end else begin
      if (regWe) begin
        case (addrE)
          ADDR_DIR:  dirQ  <= regWdata;
          ADDR_SEL:  selQ  <= regWdata;
          ADDR_CTRL: ctrlQ <= regWdata[CTRL_W-1:0];
          default: ;
        endcase
      end
      wakeReqQ <= wakeEvt;
      if (wdtReset) begin
        asleepQ <= 1'b0;
        flagQ   <= 1'b0;
      end else if (wakeEvt) begin
        asleepQ <= 1'b0;
        flagQ   <= 1'b1;
      end else if (enterSleep) begin
        asleepQ <= 1'b1;
      end
    end
  end

  always_comb begin
    case (addrE)
      ADDR_DATA: regRdata = syncIn;
      ADDR_DIR:  regRdata = '0;
      ADDR_SEL:  regRdata = selQ;
      default:   regRdata = {flagQ, ctrlQ};
    endcase
  end

  assign clkSel       = selQ[PAIR_N-1:0];
  assign counterSrcRc = selQ[2];
  assign puDisable    = ctrlQ[0];
  assign wakeReq      = wakeReqQ;
  assign inSleep      = asleepQ;

  assert_wake_single_R7: assert property (
    @(posedge clk) disable iff (!rstN) wakeReqQ |=> !wakeReqQ);
  assert_wake_needs_sleep_R7: assert property (
    @(posedge clk) disable iff (!rstN) !asleepQ |=> !wakeReqQ);
  assert_flag_with_wake_R7: assert property (
    @(posedge clk) disable iff (!rstN) $rose(flagQ) |-> wakeReqQ);
  assert_wdt_clears_R8: assert property (
    @(posedge clk) disable iff (!rstN) wdtReset |=> (!flagQ && !asleepQ));

endmodule

// File: rtl/pinport_top.sv
`timescale 1ns/1ps
module pinport_top
  import pinport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [PIN_N-1:0]  regWdata,
  output logic [PIN_N-1:0]  regRdata,
  input  logic [PIN_N-1:0]  padIn,
  output logic [PIN_N-1:0]  padOut,
  output logic [PIN_N-1:0]  padOe,
  output logic [PIN_N-1:0]  padPu,
  input  logic              timerClk,
  input  logic              sleepReq,
  input  logic              wdtReset,
  output logic              wakeReq,
  output logic              inSleep,
  output logic              counterSrcRc
);

  dpStrobe_t         strobe;
  logic [PIN_N-1:0]  dirQ;
  logic [PAIR_N-1:0] clkSel;
  logic              puDisable;
  logic [PIN_N-1:0]  syncIn;
  logic              changeDet;

  pinport_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .regWe        (regWe),
    .regAddr      (regAddr),
    .regWdata     (regWdata),
    .regRdata     (regRdata),
    .sleepReq     (sleepReq),
    .wdtReset     (wdtReset),
    .syncIn       (syncIn),
    .changeDet    (changeDet),
    .strobe       (strobe),
    .dirQ         (dirQ),
    .clkSel       (clkSel),
    .puDisable    (puDisable),
    .counterSrcRc (counterSrcRc),
    .wakeReq      (wakeReq),
    .inSleep      (inSleep)
  );

  pinport_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dirIn     (dirQ),
    .clkSel    (clkSel),
    .puDisable (puDisable),
    .timerClk  (timerClk),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .padPu     (padPu),
    .syncIn    (syncIn),
    .changeDet (changeDet)
  );

endmodule

// File: tb/sim_pinport_top.sv
`timescale 1ns/1ps
module sim_pinport_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       regWe;
  logic [1:0] regAddr;
  logic [3:0] regWdata;
  logic [3:0] regRdata;
  logic [3:0] padIn;
  logic [3:0] padOut;
  logic [3:0] padOe;
  logic [3:0] padPu;
  logic       timerClk;
  logic       sleepReq;
  logic       wdtReset;
  logic       wakeReq;
  logic       inSleep;
  logic       counterSrcRc;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  pinport_top u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .padPu(padPu), .timerClk(timerClk),
    .sleepReq(sleepReq), .wdtReset(wdtReset), .wakeReq(wakeReq),
    .inSleep(inSleep), .counterSrcRc(counterSrcRc)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [3:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic wdtPulse();
    @(negedge clk); wdtReset = 1'b1;
    @(negedge clk); wdtReset = 1'b0;
  endtask

  // expected {padOut, padOe} from latch, direction, select and clock level
  function automatic logic [7:0] expPads(logic [3:0] l, logic [3:0] d, logic [1:0] s, logic c);
    logic [3:0] v;
    logic [3:0] o;
    logic [3:0] e;
    v[0] = s[0] ? c  : l[0];
    v[3] = s[0] ? ~c : l[3];
    v[1] = s[1] ? c  : l[1];
    v[2] = s[1] ? ~c : l[2];
    o = {v[3], 1'b0, 1'b0, v[0]};
    e = {~d[3], ~d[2] & ~v[2], ~d[1] & ~v[1], ~d[0]};
    return {o, e};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] r;
    rstN = 1'b0; regWe = 1'b0; regAddr = '0; regWdata = '0; padIn = '0;
    timerClk = 1'b0; sleepReq = 1'b0; wdtReset = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    check("R1 reset oe", {4'b0, padOe}, 8'h00);
    check("R5 reset pullup", {4'b0, padPu}, 8'h09);
    check("R10 reset out", {4'b0, padOut}, 8'h00);
    check("R7 reset wake/sleep", {6'b0, wakeReq, inSleep}, 8'h00);
    check("R9 reset rc select", {7'b0, counterSrcRc}, 8'h00);
    rd(2'd3, r); check("R10 reset ctrl", {4'b0, r}, 8'h00);
    rd(2'd2, r); check("R10 reset sel", {4'b0, r}, 8'h00);

    // output sweep: every select, direction and latch value at both clock levels
    for (int s = 0; s < 4; s++) begin
      wr(2'd2, 4'(s));
      for (int d = 0; d < 16; d++) begin
        wr(2'd1, 4'(d));
        for (int l = 0; l < 16; l++) begin
          wr(2'd0, 4'(l));
          for (int c = 0; c < 2; c++) begin
            timerClk = 1'(c);
            #1;
            check("R2 R3 R4 R10 pads", {padOut, padOe},
                  expPads(4'(l), 4'(d), 2'(s), 1'(c)));
          end
        end
      end
    end
    rd(2'd1, r); check("R1 dir reads zero", {4'b0, r}, 8'h00);

    // select bit 2 and readback
    wr(2'd2, 4'b1110);
    rd(2'd2, r); check("R9 sel readback", {4'b0, r}, 8'h0e);
    check("R9 rc select high", {7'b0, counterSrcRc}, 8'h01);
    wr(2'd2, 4'b0000);
    check("R9 rc select low", {7'b0, counterSrcRc}, 8'h00);

    // pull-up sweep
    for (int p = 0; p < 2; p++) begin
      wr(2'd3, {3'b0, 1'(p)});
      for (int d = 0; d < 16; d++) begin
        wr(2'd1, 4'(d));
        check("R5 pullup", {4'b0, padPu},
              {4'b0, 4'(d) & {~1'(p), 2'b00, ~1'(p)}});
      end
    end

    // read path latency
    wr(2'd1, 4'hF);
    wr(2'd3, 4'h0);
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); padIn = 4'(v);
      repeat (2) @(negedge clk);
      rd(2'd0, r); check("R10 sync read", {4'b0, r}, 8'(v));
    end
    @(negedge clk); padIn = 4'h0;
    @(negedge clk);
    rd(2'd0, r); check("R10 one edge not yet visible", {4'b0, r}, 8'h0f);
    @(negedge clk);
    rd(2'd0, r); check("R10 two edges visible", {4'b0, r}, 8'h00);

    // wake on each pin, both directions
    for (int i = 0; i < 4; i++) begin
      for (int pol = 0; pol < 2; pol++) begin
        logic [3:0] base;
        base = pol ? 4'hF : 4'h0;
        @(negedge clk); padIn = base;
        repeat (3) @(negedge clk);
        sleepReq = 1'b1;
        @(negedge clk); sleepReq = 1'b0;
        check("R7 enter sleep", {7'b0, inSleep}, 8'h01);
        @(negedge clk);
        check("R7 quiet sleep", {7'b0, wakeReq}, 8'h00);
        padIn = base ^ (4'b1 << i);
        @(negedge clk); check("R7 wake edge1", {7'b0, wakeReq}, 8'h00);
        @(negedge clk); check("R7 wake edge2", {7'b0, wakeReq}, 8'h00);
        @(negedge clk);
        check("R7 wake edge3", {6'b0, wakeReq, inSleep}, 8'h02);
        rd(2'd3, r); check("R7 flag set", {4'b0, r}, 8'h08);
        @(negedge clk); check("R7 wake pulse ends", {7'b0, wakeReq}, 8'h00);
        wdtPulse();
        rd(2'd3, r); check("R8 flag cleared", {4'b0, r}, 8'h00);
      end
    end

    // change while awake: no wake
    @(negedge clk); padIn = 4'h5;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R7 awake no wake", {6'b0, wakeReq, inSleep}, 8'h00);
    end
    rd(2'd3, r); check("R7 awake flag clear", {4'b0, r}, 8'h00);

    // wake disabled
    wr(2'd3, 4'b0010);
    repeat (3) @(negedge clk);
    sleepReq = 1'b1;
    @(negedge clk); sleepReq = 1'b0;
    padIn = 4'hA;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R6 disabled stays asleep", {6'b0, wakeReq, inSleep}, 8'h01);
    end
    rd(2'd3, r); check("R6 no flag", {4'b0, r}, 8'h02);
    wdtPulse();
    check("R8 watchdog ends sleep", {7'b0, inSleep}, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule